// File: doc/BRIEF.md
# Accumulator Execution Unit

This unit carries out the accumulator-oriented arithmetic and logic instructions of a small 8-bit processor core. On a start pulse it decodes the opcode and picks the second operand from one of three sources: a read port into the core's banked register file (general registers R0–R3 and the two data-pointer halves), an immediate byte that the fetch stage has already supplied, or a byte read from memory at the data pointer. The unit also handles single-operand instructions: rotates, complement, increment and decrement of the accumulator, and increment and decrement of the 16-bit data pointer.

The architectural state stays in the surrounding core. The unit samples the accumulator and the active bank's data pointer when an instruction starts. It returns its result as a one-cycle write pulse with write data for either the accumulator or the data pointer, together with a done pulse. An instruction that reads memory raises a request, holds the address stable until the response arrives, and retires in the cycle after the response. Opcodes outside the supported set retire with an illegal flag and write nothing.

Top module: `acc_exec`

## Requirements
- R1: Opcodes 0x80–0x87 compute A AND operand, 0x88–0x8F compute A OR operand, and 0x90–0x97 compute A XOR operand. The result is written to the accumulator.
- R2: Opcodes 0xA0–0xA7 write A + operand and opcodes 0xB0–0xB7 write A − operand, both modulo 256.
- R3: In those five groups, opcode bits [2:0] select the operand. Values 0–5 read R0, R1, R2, R3, DPH and DPL from the register read port. During the start cycle, reg_rd_idx equals opcode[2:0] and reg_rd_bank equals bank_sel.
- R4: Operand index 6 uses imm_byte. imm_used is high in the start cycle exactly for these opcodes.
- R5: Operand index 7 reads memory. In the cycle after start, mem_req rises with mem_addr equal to the data pointer {DPH, DPL}. Both stay unchanged until mem_rvalid is high. In the cycle after mem_rvalid, mem_req is low and the accumulator write carries the result computed with mem_rdata.
- R6: 0x98 rotates A left by one bit (bit 7 moves into bit 0). 0x9A rotates A right by one bit (bit 0 moves into bit 7).
- R7: 0x9E writes A + 1 and 0x9F writes A − 1, both modulo 256.
- R8: 0x9C writes the data pointer + 1 and 0x9D writes the data pointer − 1, both modulo 65536. The write goes through dptr_we/dptr_wd, and the accumulator is not written.
- R9: 0x0F writes the bitwise complement of A.
- R10: An instruction that does not read memory retires in the cycle after start. done and exactly one write-enable are high for one cycle only.
- R11: Any other opcode (for example 0x99, 0x9B, 0xA8–0xAF, 0x00) raises illegal and done for one cycle, with no accumulator or data-pointer write.
- R12: A start pulse that arrives while a memory read is outstanding is ignored.
- R13: While reset is active and after it is released, done, illegal, acc_we, dptr_we, mem_req and imm_used are low until an instruction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Instruction opcode |
| bank_sel | input | 1 | Active register bank |
| imm_byte | input | 8 | Already-fetched byte following the opcode |
| acc_q | input | 8 | Current accumulator value |
| dptr_q | input | 16 | Data pointer of the active bank |
| reg_rd_bank | output | 1 | Register read port bank |
| reg_rd_idx | output | 3 | Register read port index (0–5) |
| reg_rd_data | input | 8 | Register read port data, same cycle |
| imm_used | output | 1 | Instruction consumes the immediate byte |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 8 | Memory response data |
| acc_we | output | 1 | Accumulator write pulse |
| acc_wd | output | 8 | Accumulator write data |
| dptr_we | output | 1 | Data pointer write pulse |
| dptr_wd | output | 16 | Data pointer write data |
| done | output | 1 | Instruction retired |
| illegal | output | 1 | Retired opcode is unsupported |

## Verification
The assertions assume that memory raises mem_rvalid only while mem_req is high, and that the core keeps acc_q and the register file unchanged until a write pulse commits. The bench acts as the register file and the memory. It updates its state only when it sees a write, and it answers each request after a chosen delay of zero to three cycles. Start is raised only when the unit is idle, except for one deliberate start during a memory wait that checks the ignore rule.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int OPC_W = 8;
  localparam int IDX_W = 3;

  localparam logic [4:0] GRP_AND = 5'b10000;
  localparam logic [4:0] GRP_OR  = 5'b10001;
  localparam logic [4:0] GRP_XOR = 5'b10010;
  localparam logic [4:0] GRP_MSC = 5'b10011;
  localparam logic [4:0] GRP_ADD = 5'b10100;
  localparam logic [4:0] GRP_SUB = 5'b10110;
  localparam logic [OPC_W-1:0] OPC_NOT = 8'h0F;

  typedef enum logic [3:0] {
    FN_NONE, FN_AND, FN_OR, FN_XOR, FN_ADD, FN_SUB, FN_ROL, FN_ROR,
    FN_INCA, FN_DECA, FN_INCD, FN_DECD, FN_NOT
  } alu_fn_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_IMM, SRC_MEM} src_e;

  typedef struct packed {
    alu_fn_e fn;
    src_e    src;
    logic    bad;
  } dec_t;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
endpackage

// File: rtl/acc_exec_rst_sync.sv
module acc_exec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain <= '0;
    else           chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/acc_exec_opdec.sv
module acc_exec_opdec
  import acc_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  logic             grp;
  logic [IDX_W-1:0] idx;

  assign idx = opcode[IDX_W-1:0];

  always_comb begin
    dec = '{fn: FN_NONE, src: SRC_NONE, bad: 1'b1};
    grp = 1'b0;
    case (opcode[OPC_W-1:IDX_W])
      GRP_AND: begin dec.fn = FN_AND; grp = 1'b1; end
      GRP_OR:  begin dec.fn = FN_OR;  grp = 1'b1; end
      GRP_XOR: begin dec.fn = FN_XOR; grp = 1'b1; end
      GRP_ADD: begin dec.fn = FN_ADD; grp = 1'b1; end
      GRP_SUB: begin dec.fn = FN_SUB; grp = 1'b1; end
      GRP_MSC: begin
        dec.bad = 1'b0;
        case (idx)
          3'd0:    dec.fn = FN_ROL;
          3'd2:    dec.fn = FN_ROR;
          3'd4:    dec.fn = FN_INCD;
          3'd5:    dec.fn = FN_DECD;
          3'd6:    dec.fn = FN_INCA;
          3'd7:    dec.fn = FN_DECA;
          default: dec.bad = 1'b1;
        endcase
      end
      default: begin
        if (opcode == OPC_NOT) begin
          dec.fn  = FN_NOT;
          dec.bad = 1'b0;
        end
      end
    endcase
    if (grp) begin
      dec.bad = 1'b0;
      if (idx == 3'd7)      dec.src = SRC_MEM;
      else if (idx == 3'd6) dec.src = SRC_IMM;
      else                  dec.src = SRC_REG;
    end
  end
endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_ROL:  y = {a[DATA_W-2:0], a[DATA_W-1]};
      FN_ROR:  y = {a[0], a[DATA_W-1:1]};
      FN_INCA: y = a + ONE;
      FN_DECA: y = a - ONE;
      FN_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/acc_exec_ptr.sv
module acc_exec_ptr
  import acc_exec_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  alu_fn_e          fn,
  input  logic [PTR_W-1:0] d,
  output logic [PTR_W-1:0] y
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_comb begin
    case (fn)
      FN_INCD: y = d + ONE;
      FN_DECD: y = d - ONE;
      default: y = d;
    endcase
  end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                bank_sel,
  input  logic [DATA_W-1:0]   imm_byte,
  input  logic [DATA_W-1:0]   acc_q,
  input  logic [2*DATA_W-1:0] dptr_q,
  output logic                reg_rd_bank,
  output logic [IDX_W-1:0]    reg_rd_idx,
  input  logic [DATA_W-1:0]   reg_rd_data,
  output logic                imm_used,
  output logic                mem_req,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                acc_we,
  output logic [DATA_W-1:0]   acc_wd,
  output logic                dptr_we,
  output logic [2*DATA_W-1:0] dptr_wd,
  output logic                done,
  output logic                illegal
);
  localparam int PTR_W = 2 * DATA_W;

  logic rst_n_s;
  acc_exec_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dec_t dec;
  acc_exec_opdec u_dec (.opcode(opcode), .dec(dec));

  st_e               st, st_n;
  alu_fn_e           fn_q, fn_n;
  logic [DATA_W-1:0] a_q, a_n;
  logic              take;

  alu_fn_e           alu_fn;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y;
  logic [PTR_W-1:0]  ptr_y;

  logic                mem_req_n, acc_we_n, dptr_we_n, done_n, illegal_n;
  logic [PTR_W-1:0]    mem_addr_n, dptr_wd_n;
  logic [DATA_W-1:0]   acc_wd_n;

  assign reg_rd_bank = bank_sel;
  assign reg_rd_idx  = opcode[IDX_W-1:0];
  assign take        = start && (st == ST_IDLE);
  assign imm_used    = take && !dec.bad && (dec.src == SRC_IMM);

  // operand selection: live sources when idle, memory data while waiting
  always_comb begin
    if (st == ST_WAIT) begin
      alu_fn = fn_q;
      alu_a  = a_q;
      alu_b  = mem_rdata;
    end else begin
      alu_fn = dec.fn;
      alu_a  = acc_q;
      case (dec.src)
        SRC_REG: alu_b = reg_rd_data;
        SRC_IMM: alu_b = imm_byte;
        default: alu_b = '0;
      endcase
    end
  end

  acc_exec_alu #(.DATA_W(DATA_W)) u_alu (
    .fn(alu_fn), .a(alu_a), .b(alu_b), .y(alu_y)
  );

  acc_exec_ptr #(.PTR_W(PTR_W)) u_ptr (
    .fn(dec.fn), .d(dptr_q), .y(ptr_y)
  );

  // next-state
  always_comb begin
    st_n       = st;
    fn_n       = fn_q;
    a_n        = a_q;
    mem_req_n  = mem_req;
    mem_addr_n = mem_addr;
    acc_wd_n   = acc_wd;
    dptr_wd_n  = dptr_wd;
    acc_we_n   = 1'b0;
    dptr_we_n  = 1'b0;
    done_n     = 1'b0;
    illegal_n  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (take) begin
          fn_n = dec.fn;
          a_n  = acc_q;
          if (dec.bad) begin
            done_n    = 1'b1;
            illegal_n = 1'b1;
          end else if (dec.src == SRC_MEM) begin
            st_n       = ST_WAIT;
            mem_req_n  = 1'b1;
            mem_addr_n = dptr_q;
          end else if (dec.fn == FN_INCD || dec.fn == FN_DECD) begin
            dptr_we_n = 1'b1;
            dptr_wd_n = ptr_y;
            done_n    = 1'b1;
          end else begin
            acc_we_n = 1'b1;
            acc_wd_n = alu_y;
            done_n   = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          st_n      = ST_IDLE;
          mem_req_n = 1'b0;
          acc_we_n  = 1'b1;
          acc_wd_n  = alu_y;
          done_n    = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st       <= ST_IDLE;
      fn_q     <= FN_NONE;
      a_q      <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      acc_we   <= 1'b0;
      acc_wd   <= '0;
      dptr_we  <= 1'b0;
      dptr_wd  <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      st       <= st_n;
      fn_q     <= fn_n;
      a_q      <= a_n;
      mem_req  <= mem_req_n;
      mem_addr <= mem_addr_n;
      acc_we   <= acc_we_n;
      acc_wd   <= acc_wd_n;
      dptr_we  <= dptr_we_n;
      dptr_wd  <= dptr_wd_n;
      done     <= done_n;
      illegal  <= illegal_n;
    end
  end
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                imm_used,
  input logic                mem_req,
  input logic [2*DATA_W-1:0] mem_addr,
  input logic                mem_rvalid,
  input logic                acc_we,
  input logic                dptr_we,
  input logic                done,
  input logic                illegal
);
  // R11: at most one effect per retirement
  p_one_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we, dptr_we, illegal}));

  // R10: an effect only comes with done
  p_effect_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we || dptr_we || illegal) |-> done);

  // R10: done always carries one effect
  p_done_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_we || dptr_we || illegal));

  // R5: request and address held while waiting
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R5: response retires the instruction next cycle
  p_req_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (!mem_req && done && acc_we));

  // R4: immediate instructions retire next cycle into A without memory
  p_imm_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    imm_used |=> (done && acc_we && !mem_req));

  // R12: no retirement while a read is still outstanding
  p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> !done);

  // R13: outputs quiet in reset
  p_reset_quiet_r13: assert property (@(posedge clk)
    !rst_n |-> (!done && !mem_req && !acc_we && !dptr_we && !illegal));
endmodule

bind acc_exec acc_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .imm_used(imm_used), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .acc_we(acc_we),
  .dptr_we(dptr_we), .done(done), .illegal(illegal)
);

// File: tb/acc_exec_test.sv
module acc_exec_test;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        start, bank_sel, reg_rd_bank, imm_used, mem_req, mem_rvalid;
  logic        acc_we, dptr_we, done, illegal;
  logic [7:0]  opcode, imm_byte, acc_q, reg_rd_data, mem_rdata, acc_wd;
  logic [2:0]  reg_rd_idx;
  logic [15:0] dptr_q, mem_addr, dptr_wd;

  logic [7:0] rf [2][6];
  logic [7:0] acc;
  int total = 0;
  int bad = 0;

  assign acc_q       = acc;
  assign dptr_q      = {rf[bank_sel][4], rf[bank_sel][5]};
  assign reg_rd_data = (reg_rd_idx < 3'd6) ? rf[reg_rd_bank][reg_rd_idx] : 8'h00;

  acc_exec uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .bank_sel(bank_sel),
    .imm_byte(imm_byte), .acc_q(acc_q), .dptr_q(dptr_q), .reg_rd_bank(reg_rd_bank),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data), .imm_used(imm_used),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .acc_we(acc_we), .acc_wd(acc_wd), .dptr_we(dptr_we),
    .dptr_wd(dptr_wd), .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_grp(input logic [7:0] op);
    return op[7:3] inside {5'h10, 5'h11, 5'h12, 5'h14, 5'h16};
  endfunction

  // 0 illegal, 1 accumulator, 2 memory operand, 3 data pointer
  function automatic int kind(input logic [7:0] op);
    if (in_grp(op)) return (op[2:0] == 3'd7) ? 2 : 1;
    if (op inside {8'h98, 8'h9A, 8'h9E, 8'h9F, 8'h0F}) return 1;
    if (op inside {8'h9C, 8'h9D}) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op[7:3])
      5'h10: return a & b;
      5'h11: return a | b;
      5'h12: return a ^ b;
      5'h14: return 8'((a + b) % 256);
      5'h16: return 8'((a + 256 - b) % 256);
      default: ;
    endcase
    case (op)
      8'h98: return {a[6:0], a[7]};
      8'h9A: return {a[0], a[7:1]};
      8'h9E: return 8'((a + 1) % 256);
      8'h9F: return 8'((a + 255) % 256);
      8'h0F: return a ^ 8'hFF;
      default: return a;
    endcase
  endfunction

  task automatic do_op(input logic [7:0] op, input logic bnk, input logic [7:0] imm,
                       input int lat, input logic [7:0] md, input bit intrude, input string tag);
    int k;
    logic [2:0] ix;
    logic [7:0] b, e;
    logic [15:0] dp, de;
    k  = kind(op);
    ix = op[2:0];
    dp = {rf[bnk][4], rf[bnk][5]};
    b  = 8'h00;
    if (in_grp(op)) b = (ix <= 3'd5) ? rf[bnk][ix] : (ix == 3'd6) ? imm : md;
    @(negedge clk);
    bank_sel = bnk; opcode = op; imm_byte = imm; start = 1'b1;
    #1;
    chk(imm_used == (in_grp(op) && ix == 3'd6), {tag, " R4 imm_used"}, imm_used,
        in_grp(op) && ix == 3'd6);
    if (in_grp(op) && ix <= 3'd5)
      chk(reg_rd_idx == ix && reg_rd_bank == bnk, {tag, " R3 read port"},
          {reg_rd_bank, reg_rd_idx}, {bnk, ix});
    @(negedge clk);
    start = 1'b0;
    if (k == 2) begin
      chk(mem_req && mem_addr == dp && !done, {tag, " R5 request"}, {mem_req, mem_addr}, {1'b1, dp});
      for (int i = 0; i < lat; i++) begin
        if (intrude && i == 0) begin opcode = 8'h9C; start = 1'b1; end
        @(negedge clk);
        start = 1'b0;
        chk(mem_req && mem_addr == dp && !done && !dptr_we, {tag, " R5 R12 waiting"},
            {done, dptr_we, mem_req}, 3'b001);
      end
      mem_rvalid = 1'b1; mem_rdata = md;
      @(negedge clk);
      mem_rvalid = 1'b0;
      chk(!mem_req, {tag, " R5 request drop"}, mem_req, 0);
    end
    e = model(op, acc, b);
    de = (op == 8'h9C) ? 16'((dp + 1) % 65536) : 16'((dp + 65535) % 65536);
    case (k)
      0: chk(done && illegal && !acc_we && !dptr_we, {tag, " R11 illegal"},
             {done, illegal, acc_we, dptr_we}, 4'b1100);
      3: begin
        chk(done && dptr_we && !acc_we && !illegal, {tag, " R8 ptr strobe"},
            {done, dptr_we, acc_we, illegal}, 4'b1100);
        chk(dptr_wd == de, {tag, " R8 ptr value"}, dptr_wd, de);
        rf[bnk][4] = de[15:8]; rf[bnk][5] = de[7:0];
      end
      default: begin
        chk(done && acc_we && !dptr_we && !illegal, {tag, " R10 acc strobe"},
            {done, acc_we, dptr_we, illegal}, 4'b1100);
        chk(acc_wd == e, {tag, " value"}, acc_wd, e);
        acc = e;
      end
    endcase
    @(negedge clk);
    chk(!done && !acc_we && !dptr_we && !illegal, {tag, " R10 single pulse"},
        {done, acc_we, dptr_we, illegal}, 0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; bank_sel = 1'b0; imm_byte = 8'h00;
    mem_rvalid = 1'b0; mem_rdata = 8'h00; acc = 8'h5A;
    rf[0][0] = 8'h3C; rf[0][1] = 8'h81; rf[0][2] = 8'hC0; rf[0][3] = 8'h07;
    rf[0][4] = 8'h12; rf[0][5] = 8'h34;
    rf[1][0] = 8'hF0; rf[1][1] = 8'h0F; rf[1][2] = 8'h55; rf[1][3] = 8'hAA;
    rf[1][4] = 8'hBE; rf[1][5] = 8'hEF;
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !acc_we && !dptr_we && !illegal && !imm_used, "R13 in reset",
        {done, mem_req, acc_we, dptr_we, illegal}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !mem_req && !acc_we && !dptr_we && !illegal && !imm_used, "R13 after reset",
        {done, mem_req, acc_we, dptr_we, illegal}, 0);

    do_op(8'h80, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R1 AND R0 bank0");
    do_op(8'h89, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R1 OR R1 bank1");
    do_op(8'h94, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R1 XOR DPH");
    do_op(8'h8D, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R1 OR DPL bank1");
    do_op(8'h86, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R1 AND imm zero");
    do_op(8'h8E, 1'b0, 8'hC8, 0, 8'h00, 1'b0, "R1 OR imm");
    do_op(8'hA6, 1'b0, 8'h50, 0, 8'h00, 1'b0, "R2 ADD imm wrap");
    do_op(8'hB2, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R2 SUB R2 wrap");
    do_op(8'hA3, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R2 ADD R3 bank1");
    do_op(8'hB6, 1'b0, 8'h01, 0, 8'h00, 1'b0, "R2 SUB imm");
    do_op(8'hA7, 1'b0, 8'h00, 0, 8'h9B, 1'b0, "R5 ADD mem lat0");
    do_op(8'h97, 1'b1, 8'h00, 3, 8'h66, 1'b1, "R5 R12 XOR mem lat3");
    do_op(8'h87, 1'b0, 8'h00, 1, 8'h0F, 1'b0, "R5 AND mem lat1");
    do_op(8'hB7, 1'b1, 8'h00, 2, 8'hFF, 1'b0, "R5 SUB mem lat2");
    do_op(8'h8E, 1'b0, 8'h81, 0, 8'h00, 1'b0, "R1 OR imm set");
    do_op(8'h98, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R6 rotate left");
    do_op(8'h9A, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R6 rotate right");
    do_op(8'h9A, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R6 rotate right wrap");
    do_op(8'h8E, 1'b0, 8'hFF, 0, 8'h00, 1'b0, "R1 OR imm all ones");
    do_op(8'h9E, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R7 INC A wrap");
    do_op(8'h9F, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R7 DEC A wrap");
    do_op(8'h9E, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R7 INC A");
    do_op(8'h0F, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R9 complement");
    do_op(8'h0F, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R9 complement again");
    rf[0][4] = 8'hFF; rf[0][5] = 8'hFF;
    do_op(8'h9C, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R8 INC DPTR wrap");
    do_op(8'h9D, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R8 DEC DPTR wrap");
    do_op(8'h9C, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R8 INC DPTR bank1");
    rf[1][5] = 8'h00;
    do_op(8'h9D, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R8 DEC DPTR borrow");
    do_op(8'h99, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R11 opcode 99");
    do_op(8'h9B, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R11 opcode 9B");
    do_op(8'hAE, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R11 opcode AE");
    do_op(8'h00, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R11 opcode 00");
    do_op(8'hD8, 1'b0, 8'h00, 0, 8'h00, 1'b0, "R11 opcode D8");
    do_op(8'h90, 1'b1, 8'h00, 0, 8'h00, 1'b0, "R1 XOR after illegal");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule